// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block listens on a two-wire serial bus for the address phase of a transfer aimed at this device. Both bus lines enter as plain level inputs and pass through a two-flop synchronizer. Once the block has seen a START condition, it shifts in eight bits on the rising edges of SCL. It then compares the upper seven bits with the own address held in an 8-bit configuration register. Bit 0 of that register enables matching of the all-zero general call address.

On a match, the block pulls SDA low through the ninth clock as the acknowledge. It then raises an interrupt flag and pulls SCL low, which stalls the bus until software clears the flag by writing a one. It also reports the direction bit that was received and whether the hit was a general call. An address that does not match gets no acknowledge, and the block goes back to waiting for a START. Transfer of data bytes, clock generation and arbitration are handled elsewhere. The open-drain lines are driven through separate pull-low outputs.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset, `own_cfg` reads 0xFE (own address 7'h7F, general call disabled), and `irq`, `scl_pull` and `sda_pull` are all 0.
- R2: When the received byte's bits 7..1 equal `own_cfg[7:1]`, the block holds SDA low while SCL is high in the ninth clock. After SCL falls at the end of that clock, `irq` goes to 1.
- R3: When the address byte matches neither the own address nor an enabled general call, SDA stays released in the ninth clock and `irq` stays 0. A later START with a matching address is still recognized.
- R4: The byte 0x00 or 0x01 is a general call. It is acknowledged only when `own_cfg[0]` is 1, and on that hit `gc_hit` reads 1. An own-address hit sets `gc_hit` to 0.
- R5: `rw_bit` takes the eighth received bit (the LSB of the address byte, 1 = read, 0 = write) of the last matched address.
- R6: While `irq` is 1, `scl_pull` is 1, so the bus SCL stays low even when the master releases it. One cycle with `flag_we` = 1 and `flag_wdata` = 1 clears `irq` and releases SCL.
- R7: A flag write with `flag_wdata` = 0 changes nothing: `irq` and `scl_pull` stay 1.
- R8: A START or STOP seen part-way through the eight address bits throws away the bits collected so far. After a repeated START, a full new address is captured. After a STOP, the bits that follow without a new START get no acknowledge.
- R9: A write with `cfg_we` = 1 loads `cfg_wdata` into `own_cfg`, and the next address phase is compared against the new value.
- R10: An all-zero address never matches as an own address. With `own_cfg` = 0x00 the byte 0x00 gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Level seen on the SCL wire |
| sda_in | input | 1 | Level seen on the SDA wire |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_we | input | 1 | Write strobe for the address register |
| cfg_wdata | input | 8 | Own address in bits 7..1, general call enable in bit 0 |
| own_cfg | output | 8 | Current address register value |
| flag_we | input | 1 | Write strobe for the interrupt flag |
| flag_wdata | input | 1 | 1 clears the flag, 0 has no effect |
| irq | output | 1 | Address-hit interrupt flag |
| rw_bit | output | 1 | Direction bit of the last hit, 1 = read |
| gc_hit | output | 1 | Last hit was a general call |

## Verification
The recognizer is driven with these bus patterns:
- Exact own-address bytes with each value of the direction bit. These separate the compare from the direction capture.
- A byte that differs only in the last address bit. This shows that all seven address bits are compared.
- The zero byte under three settings: general call enabled, general call disabled, and an own address of zero. These separate the general call path from the own-address path.
- Address phases cut short by a repeated START and by a STOP. These show that a partial byte never carries over into the next one.
- While the bus is stalled, the master releases SCL and the flag is written first with a zero and then with a one. This separates holding the flag from clearing it.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  localparam int ADDR_BITS  = 7;
  localparam int FRAME_BITS = ADDR_BITS + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK_WAIT,
    ST_ACK,
    ST_HOLD
  } rcv_state_e;

  typedef struct packed {
    logic hit;
    logic gc;
  } cmp_res_t;

  // Compare a received address frame against the configuration word.
  // The all-zero address is only ever a general call.
  function automatic cmp_res_t addr_compare(input logic [FRAME_BITS-1:0] rx,
                                            input logic [FRAME_BITS-1:0] cfg);
    cmp_res_t r;
    logic     zero_addr;
    zero_addr = (rx[FRAME_BITS-1:1] == '0);
    r.gc  = zero_addr && cfg[0];
    r.hit = r.gc || (!zero_addr && (rx[FRAME_BITS-1:1] == cfg[FRAME_BITS-1:1]));
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_now,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= 1'b1;
    else        q_prev <= chain[STAGES-1];
  end

  assign q_now = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl_now,
  input  logic scl_prev,
  input  logic sda_now,
  input  logic sda_prev,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_steady_high;

  assign scl_steady_high = scl_now && scl_prev;
  assign start_ev = scl_steady_high && sda_prev && !sda_now;
  assign stop_ev  = scl_steady_high && !sda_prev && sda_now;
  assign scl_rise = scl_now && !scl_prev;
  assign scl_fall = !scl_now && scl_prev;
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_addr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_ev,
  input  logic                  stop_ev,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  sda_now,
  input  logic [FRAME_BITS-1:0] cfg,
  input  logic                  flag_q,
  output logic                  sda_pull,
  output logic                  set_flag,
  output logic                  match_ev,
  output logic                  rw_q,
  output logic                  gc_q
);
  rcv_state_e            state;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic                  ninth_high;
  logic [FRAME_BITS-1:0] frame;
  logic                  last_bit;
  cmp_res_t              cmp;

  assign frame    = {shreg, sda_now};
  assign last_bit = (bit_cnt == CNT_W'(FRAME_BITS - 1));
  assign cmp      = addr_compare(frame, cfg);

  assign match_ev = (state == ST_SHIFT) && !start_ev && !stop_ev &&
                    scl_rise && last_bit && cmp.hit;
  assign set_flag = (state == ST_ACK) && scl_fall && ninth_high;
  assign sda_pull = (state == ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      ninth_high <= 1'b0;
      rw_q       <= 1'b0;
      gc_q       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ev) begin
            state   <= ST_SHIFT;
            bit_cnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (start_ev) begin
            bit_cnt <= '0;
          end else if (stop_ev) begin
            state <= ST_IDLE;
          end else if (scl_rise) begin
            shreg <= frame[FRAME_BITS-2:0];
            if (last_bit) begin
              bit_cnt <= '0;
              if (cmp.hit) begin
                rw_q  <= sda_now;
                gc_q  <= cmp.gc;
                state <= ST_ACK_WAIT;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall) begin
            state      <= ST_ACK;
            ninth_high <= 1'b0;
          end
        end
        ST_ACK: begin
          if (scl_rise) ninth_high <= 1'b1;
          if (set_flag) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!flag_q) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_flag_reg.sv
module i2c_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_flag,
  input  logic wr_en,
  input  logic wr_one,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               flag_q <= 1'b0;
    else if (set_flag)        flag_q <= 1'b1;
    else if (wr_en && wr_one) flag_q <= 1'b0;
  end
endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect
  import i2c_addr_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter logic [FRAME_BITS-1:0] CFG_RESET   = {{ADDR_BITS{1'b1}}, 1'b0}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  scl_pull,
  output logic                  sda_pull,
  input  logic                  cfg_we,
  input  logic [FRAME_BITS-1:0] cfg_wdata,
  output logic [FRAME_BITS-1:0] own_cfg,
  input  logic                  flag_we,
  input  logic                  flag_wdata,
  output logic                  irq,
  output logic                  rw_bit,
  output logic                  gc_hit
);
  logic scl_s, scl_p, sda_s, sda_p;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic set_flag, match_ev, flag_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_now(scl_s), .q_prev(scl_p)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_now(sda_s), .q_prev(sda_p)
  );

  i2c_bus_events u_events (
    .scl_now(scl_s), .scl_prev(scl_p), .sda_now(sda_s), .sda_prev(sda_p),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_cfg <= CFG_RESET;
    else if (cfg_we) own_cfg <= cfg_wdata;
  end

  i2c_addr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_now(sda_s), .cfg(own_cfg), .flag_q(flag_q),
    .sda_pull(sda_pull), .set_flag(set_flag), .match_ev(match_ev),
    .rw_q(rw_bit), .gc_q(gc_hit)
  );

  i2c_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .set_flag(set_flag),
    .wr_en(flag_we), .wr_one(flag_wdata), .flag_q(flag_q)
  );

  assign irq      = flag_q;
  assign scl_pull = flag_q;
endmodule

// File: rtl/i2c_addr_detect_chk.sv
module i2c_addr_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_s,
  input logic       start_ev,
  input logic       match_ev,
  input logic       sda_pull,
  input logic       scl_pull,
  input logic       irq,
  input logic       rw_bit,
  input logic       gc_hit,
  input logic [7:0] own_cfg,
  input logic       flag_we,
  input logic       flag_wdata
);
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sda_pull));  // R2

  AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);  // R2

  AST_NO_ACK_WHILE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_pull && scl_pull));  // R6

  AST_RELEASE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> $past(flag_we && flag_wdata));  // R6

  AST_FLAG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(flag_we && flag_wdata)) |=> irq);  // R7

  AST_GC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && gc_hit) |-> own_cfg[0]);  // R4

  AST_DIR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> (rw_bit == $past(sda_s)));  // R5

  AST_START_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_pull);  // R8
endmodule

bind i2c_addr_detect i2c_addr_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
  .start_ev(start_ev), .match_ev(match_ev), .sda_pull(sda_pull),
  .scl_pull(scl_pull), .irq(irq), .rw_bit(rw_bit), .gc_hit(gc_hit),
  .own_cfg(own_cfg), .flag_we(flag_we), .flag_wdata(flag_wdata)
);

// File: tb/sim_i2c_addr_detect.sv
module sim_i2c_addr_detect;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_pull, sda_pull;
  logic scl_in, sda_in;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] own_cfg;
  logic flag_we = 1'b0, flag_wdata = 1'b0;
  logic irq, rw_bit, gc_hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign scl_in = m_scl & ~scl_pull;
  assign sda_in = m_sda & ~sda_pull;

  i2c_addr_detect u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .own_cfg(own_cfg),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .irq(irq), .rw_bit(rw_bit), .gc_hit(gc_hit)
  );

  typedef struct {
    bit    ack;
    bit    rw;
    bit    gc;
    string req;
  } item_t;

  item_t exp_q[$];
  item_t obs;
  event  obs_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: pops the expected item for each finished address phase.
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard", 0, 1);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(obs.ack == e.ack, {e.req, " ack"}, int'(obs.ack), int'(e.ack));
        check(irq == e.ack, {e.req, " irq"}, int'(irq), int'(e.ack));
        if (e.ack) begin
          check(obs.rw == e.rw, {e.req, " R5 rw"}, int'(obs.rw), int'(e.rw));
          check(obs.gc == e.gc, {e.req, " R4 gc"}, int'(obs.gc), int'(e.gc));
          check(scl_pull == 1'b1, {e.req, " R6 stall"}, int'(scl_pull), 1);
        end
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b0; hold(H);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; hold(H);
    m_sda = 1'b0; hold(H);
    m_scl = 1'b1; hold(H);
    m_sda = 1'b1; hold(H);
  endtask

  task automatic clock_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hold(H);
      m_scl = 1'b1; hold(H);
      m_scl = 1'b0; hold(H);
    end
  endtask

  // Ninth clock; returns the acknowledge level seen while SCL is high.
  task automatic ninth_clock(output bit ack);
    m_sda = 1'b1; hold(H);
    m_scl = 1'b1; hold(H / 2);
    ack = !sda_in;
    hold(H / 2);
    m_scl = 1'b0; hold(H);
  endtask

  task automatic addr_phase(input logic [7:0] b, input bit e_ack, input bit e_rw,
                            input bit e_gc, input string req);
    item_t e;
    bit a;
    e.ack = e_ack; e.rw = e_rw; e.gc = e_gc; e.req = req;
    exp_q.push_back(e);
    bus_start();
    clock_bits(b, 8);
    ninth_clock(a);
    obs.ack = a; obs.rw = rw_bit; obs.gc = gc_hit;
    ->obs_ev;
    hold(1);
  endtask

  task automatic flag_write(input bit v);
    flag_we = 1'b1; flag_wdata = v; hold(1);
    flag_we = 1'b0; flag_wdata = 1'b0; hold(2);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; hold(1);
    cfg_we = 1'b0; hold(1);
  endtask

  task automatic release_and_stop();
    flag_write(1'b1);
    bus_stop();
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(2);
    // R1 reset state
    check(own_cfg == 8'hFE, "R1 own_cfg", own_cfg, 8'hFE);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 pulls", {scl_pull, sda_pull}, 0);

    // R9 configuration load and readback
    cfg_write(8'hA0);
    check(own_cfg == 8'hA0, "R9 readback", own_cfg, 8'hA0);

    // R2 / R5 write to own address
    addr_phase(8'hA0, 1'b1, 1'b0, 1'b0, "R2 own write");
    // R6 master releases SCL while stalled: wire stays low
    m_scl = 1'b1; hold(H);
    check(scl_in == 1'b0, "R6 stretch", scl_in, 0);
    // R7 writing zero keeps the flag
    flag_write(1'b0);
    check(irq == 1'b1 && scl_pull == 1'b1, "R7 zero write", {irq, scl_pull}, 2'b11);
    // R6 writing one clears and releases
    flag_write(1'b1);
    check(irq == 1'b0 && scl_in == 1'b1, "R6 clear", {irq, scl_in}, 2'b01);
    bus_stop();

    // R5 read direction
    addr_phase(8'hA1, 1'b1, 1'b1, 1'b0, "R5 own read");
    release_and_stop();

    // R3 mismatch in last address bit, then recovery
    addr_phase(8'hA2, 1'b0, 1'b0, 1'b0, "R3 mismatch");
    bus_stop();
    addr_phase(8'hA0, 1'b1, 1'b0, 1'b0, "R3 recover");
    release_and_stop();

    // R4 general call disabled, then enabled
    addr_phase(8'h00, 1'b0, 1'b0, 1'b0, "R4 gc off");
    bus_stop();
    cfg_write(8'hA1);
    addr_phase(8'h00, 1'b1, 1'b0, 1'b1, "R4 gc on");
    release_and_stop();
    addr_phase(8'hA1, 1'b1, 1'b1, 1'b0, "R4 own after gc");
    release_and_stop();

    // R8 repeated START part-way through an address
    bus_start();
    clock_bits(8'h55, 4);
    addr_phase(8'hA0, 1'b1, 1'b0, 1'b0, "R8 restart");
    release_and_stop();

    // R8 STOP part-way: following bits without START are ignored
    bus_start();
    clock_bits(8'hA0, 3);
    bus_stop();
    m_scl = 1'b0; hold(H);
    begin
      bit a;
      clock_bits(8'hA0, 8);
      ninth_clock(a);
      check(a == 1'b0 && irq == 1'b0, "R8 stop abort", {a, irq}, 0);
    end
    bus_stop();

    // R10 own address zero never matches
    cfg_write(8'h00);
    addr_phase(8'h00, 1'b0, 1'b0, 1'b0, "R10 zero own");
    bus_stop();

    // R9 new address used on next phase
    cfg_write(8'h3C);
    addr_phase(8'hA0, 1'b0, 1'b0, 1'b0, "R9 old addr");
    bus_stop();
    addr_phase(8'h3D, 1'b1, 1'b1, 1'b0, "R9 new addr");
    release_and_stop();

    hold(5);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule